// File: doc/BRIEF.md
# Pipelined Adder-Tree FIR Filter

This block is a direct-form FIR filter with a fixed coefficient set chosen at elaboration. Every tap product is formed at the same time. The products are then reduced by a binary adder tree that has a register after each of its levels. Because the tree is registered, the long carry path of a chained summation is split into one adder per cycle. The cost is a fixed and known number of extra cycles of delay.

The filter accepts one signed sample on each clock edge at which the clock enable is high, and it returns the full-precision signed convolution result. An input register and an output register can each be included or removed, and both are present by default. Each multiplier can also take a configurable number of pipeline stages on its data input and on its product, and both counts default to zero. A valid flag is delayed by the same total latency as the data, so that it rises when the first result that depends only on real samples reaches the output.

Top module: `fir_tree_filter`

## Requirements
- R1: While the clock enable is high, `dout` is y[n] = sum over k of c[k]*x[n-k], where x[n] is the n-th sample accepted since reset and any sample before the first accepted one counts as zero. The coefficient for tap k is held in bits [k*CW +: CW] of `COEFS`, and samples and coefficients are two's complement.
- R2: With the default settings (input and output registers present, no multiplier stages, five taps), result y[n] appears at `dout` after the 5th enabled edge counted from the edge that accepts x[n]. In general the latency is IN_REG + MUL_IN_STG + MUL_OUT_STG + ceil(log2(NT)) + OUT_REG enabled edges.
- R3: The products are summed pairwise over ceil(log2(NT)) registered levels. An operand left unpaired at a level is registered and passed to the next level unchanged. The output is DW+CW+ceil(log2(NT)) bits wide, so sustained full-scale positive or negative input never wraps.
- R4: While `ce` is low, no sample is accepted and `dout` and `dout_valid` hold their values, whatever `din` carries.
- R5: After reset, `dout_valid` is low. It rises on the enabled edge whose count since reset equals the total latency, and it stays high until the next reset.
- R6: A synchronous active-high `rst` clears every pipeline register, so `dout` reads 0 and `dout_valid` reads 0 on the cycle after the reset edge, and the sample history starts again from zero.
- R7: When the input and output registers are removed and stages are placed on the multiplier inputs and outputs, the latency follows the formula in R2 (for example 0+1+2+3+0 = 6 for five taps) and the results are the same as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable; a high level accepts `din` and advances the whole pipeline |
| din | input | DW | Signed input sample |
| dout | output | DW+CW+ceil(log2(NT)) | Signed full-precision filter result |
| dout_valid | output | 1 | High once the pipeline holds only results computed from accepted samples |

## Verification
The main function is exercised with several kinds of input. A unit impulse reads each coefficient out in tap order, which catches a wrong tap order, a wrong coefficient or a wrong latency. A mixed-sign burst checks that the signed products are added correctly. Long runs of +127 and -128 drive the tree to its largest positive and negative totals, so any truncated level width would show up. Gaps in the clock enable, with garbage on `din` during the gap, confirm that the data and the valid flag freeze together. A second instance with the input and output registers removed and the multipliers pipelined receives the same stream, which shows that the latency formula holds across configurations and not only at the defaults.

// File: rtl/fir_tree_pkg.sv
package fir_tree_pkg;

  // number of pairwise reduction levels needed to bring n operands to one
  function automatic int tree_levels(input int n);
    int c;
    int l;
    c = n;
    l = 0;
    while (c > 1) begin
      c = (c + 1) / 2;
      l++;
    end
    return l;
  endfunction

  // operand count present at reduction level lv (level 0 = raw products)
  function automatic int level_count(input int n, input int lv);
    int c;
    c = n;
    for (int i = 0; i < lv; i++) c = (c + 1) / 2;
    return c;
  endfunction

endpackage

// File: rtl/fir_tap_line.sv
module fir_tap_line #(
  parameter int DW     = 8,
  parameter int NT     = 5,
  parameter int IN_REG = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ce,
  input  logic signed [DW-1:0] din,
  output logic [NT*DW-1:0]     taps
);

  logic signed [DW-1:0] head;

  generate
    if (IN_REG != 0) begin : g_in_reg
      logic signed [DW-1:0] in_q;
      always_ff @(posedge clk) begin
        if (rst)     in_q <= '0;
        else if (ce) in_q <= din;
      end
      assign head = in_q;
    end else begin : g_in_wire
      assign head = din;
    end
  endgenerate

  // delayed samples x[n-1] .. x[n-NT+1]
  logic signed [DW-1:0] hist [NT-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NT - 1; i++) hist[i] <= '0;
    end else if (ce) begin
      hist[0] <= head;
      for (int i = 1; i < NT - 1; i++) hist[i] <= hist[i-1];
    end
  end

  assign taps[DW-1:0] = head;

  generate
    for (genvar k = 1; k < NT; k++) begin : g_tap
      assign taps[k*DW +: DW] = hist[k-1];
    end
  endgenerate

endmodule

// File: rtl/fir_tap_mult.sv
module fir_tap_mult #(
  parameter int                 DW      = 8,
  parameter int                 CW      = 8,
  parameter logic signed [CW-1:0] COEF  = '0,
  parameter int                 IN_STG  = 0,
  parameter int                 OUT_STG = 0,
  localparam int                PW      = DW + CW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ce,
  input  logic signed [DW-1:0] x,
  output logic signed [PW-1:0] p
);

  logic signed [DW-1:0] x_m;
  logic signed [PW-1:0] p_raw;

  generate
    if (IN_STG > 0) begin : g_in_pipe
      logic signed [DW-1:0] xs [IN_STG];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < IN_STG; i++) xs[i] <= '0;
        end else if (ce) begin
          xs[0] <= x;
          for (int i = 1; i < IN_STG; i++) xs[i] <= xs[i-1];
        end
      end
      assign x_m = xs[IN_STG-1];
    end else begin : g_in_wire
      assign x_m = x;
    end
  endgenerate

  assign p_raw = x_m * COEF;

  generate
    if (OUT_STG > 0) begin : g_out_pipe
      logic signed [PW-1:0] ps [OUT_STG];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < OUT_STG; i++) ps[i] <= '0;
        end else if (ce) begin
          ps[0] <= p_raw;
          for (int i = 1; i < OUT_STG; i++) ps[i] <= ps[i-1];
        end
      end
      assign p = ps[OUT_STG-1];
    end else begin : g_out_wire
      assign p = p_raw;
    end
  endgenerate

endmodule

// File: rtl/fir_adder_tree.sv
module fir_adder_tree
  import fir_tree_pkg::*;
#(
  parameter int NT = 5,
  parameter int IW = 16,
  parameter int OW = IW + fir_tree_pkg::tree_levels(NT)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ce,
  input  logic [NT*IW-1:0]     prods,
  output logic signed [OW-1:0] sum
);

  localparam int LEVELS = tree_levels(NT);
  localparam int TW     = OW + 2;

  logic signed [OW-1:0] leaf [NT];
  logic signed [OW-1:0] view [LEVELS][NT];
  logic signed [OW-1:0] nxt  [LEVELS][NT];
  logic signed [OW-1:0] node [LEVELS][NT];

  // sign-extend every product to the final width
  always_comb begin
    for (int j = 0; j < NT; j++) leaf[j] = OW'(signed'(prods[j*IW +: IW]));
  end

  // pair operands of each level; an odd leftover passes straight on
  always_comb begin
    int ia;
    int ib;
    int pc;
    for (int l = 0; l < LEVELS; l++) begin
      for (int j = 0; j < NT; j++) view[l][j] = (l == 0) ? leaf[j] : node[(l > 0) ? l - 1 : 0][j];
    end
    for (int l = 0; l < LEVELS; l++) begin
      pc = level_count(NT, l);
      for (int j = 0; j < NT; j++) begin
        ia = (2 * j < NT) ? 2 * j : 0;
        ib = (2 * j + 1 < NT) ? 2 * j + 1 : 0;
        if (2 * j + 1 < pc)  nxt[l][j] = view[l][ia] + view[l][ib];
        else if (2 * j < pc) nxt[l][j] = view[l][ia];
        else                 nxt[l][j] = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int l = 0; l < LEVELS; l++)
        for (int j = 0; j < NT; j++) node[l][j] <= '0;
    end else if (ce) begin
      for (int l = 0; l < LEVELS; l++)
        for (int j = 0; j < NT; j++) node[l][j] <= nxt[l][j];
    end
  end

  assign sum = node[LEVELS-1][0];

  // level totals, used only to check that no level gains or loses value
  logic signed [TW-1:0] tot [LEVELS+1];

  always_comb begin
    tot[0] = '0;
    for (int j = 0; j < NT; j++) tot[0] = tot[0] + TW'(leaf[j]);
    for (int l = 1; l <= LEVELS; l++) begin
      tot[l] = '0;
      for (int j = 0; j < NT; j++) tot[l] = tot[l] + TW'(node[l-1][j]);
    end
  end

  generate
    for (genvar lv = 1; lv <= LEVELS; lv++) begin : g_chk
      // R3: each registered level holds the whole total of the level before it
      p_level_sum_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(ce) && !$past(rst)) |-> (tot[lv] == $past(tot[lv-1])));
    end
  endgenerate

endmodule

// File: rtl/fir_tree_filter.sv
module fir_tree_filter #(
  parameter int                   DW          = 8,
  parameter int                   CW          = 8,
  parameter int                   NT          = 5,
  parameter logic [NT*CW-1:0]     COEFS       = {8'hF9, 8'h01, 8'h05, 8'hFE, 8'h03},
  parameter int                   IN_REG      = 1,
  parameter int                   OUT_REG     = 1,
  parameter int                   MUL_IN_STG  = 0,
  parameter int                   MUL_OUT_STG = 0
) (
  input  logic                                                 clk,
  input  logic                                                 rst,
  input  logic                                                 ce,
  input  logic signed [DW-1:0]                                 din,
  output logic signed [DW+CW+fir_tree_pkg::tree_levels(NT)-1:0] dout,
  output logic                                                 dout_valid
);

  localparam int PW     = DW + CW;
  localparam int LEVELS = fir_tree_pkg::tree_levels(NT);
  localparam int OW     = PW + LEVELS;
  localparam int LAT    = IN_REG + MUL_IN_STG + MUL_OUT_STG + LEVELS + OUT_REG;

  logic [NT*DW-1:0]     taps;
  logic [NT*PW-1:0]     prods;
  logic signed [OW-1:0] tree_sum;

  fir_tap_line #(.DW(DW), .NT(NT), .IN_REG(IN_REG)) u_line (
    .clk (clk),
    .rst (rst),
    .ce  (ce),
    .din (din),
    .taps(taps)
  );

  generate
    for (genvar k = 0; k < NT; k++) begin : g_mul
      logic signed [PW-1:0] pk;
      fir_tap_mult #(
        .DW     (DW),
        .CW     (CW),
        .COEF   (COEFS[k*CW +: CW]),
        .IN_STG (MUL_IN_STG),
        .OUT_STG(MUL_OUT_STG)
      ) u_mul (
        .clk(clk),
        .rst(rst),
        .ce (ce),
        .x  (taps[k*DW +: DW]),
        .p  (pk)
      );
      assign prods[k*PW +: PW] = pk;
    end
  endgenerate

  fir_adder_tree #(.NT(NT), .IW(PW), .OW(OW)) u_tree (
    .clk  (clk),
    .rst  (rst),
    .ce   (ce),
    .prods(prods),
    .sum  (tree_sum)
  );

  generate
    if (OUT_REG != 0) begin : g_out_reg
      logic signed [OW-1:0] out_q;
      always_ff @(posedge clk) begin
        if (rst)     out_q <= '0;
        else if (ce) out_q <= tree_sum;
      end
      assign dout = out_q;
    end else begin : g_out_wire
      assign dout = tree_sum;
    end
  endgenerate

  // valid flag travels with the data, one stage per cycle of latency
  logic [LAT-1:0] vld_sr;

  always_ff @(posedge clk) begin
    if (rst)     vld_sr <= '0;
    else if (ce) vld_sr <= (vld_sr << 1) | LAT'(1);
  end

  assign dout_valid = vld_sr[LAT-1];

  // enabled-edge counter kept for the latency check only
  int unsigned en_cnt;
  always_ff @(posedge clk) begin
    if (rst)                       en_cnt <= 0;
    else if (ce && en_cnt < LAT)   en_cnt <= en_cnt + 1;
  end

  // R2: valid rises exactly when the enabled-edge count reaches the latency
  p_valid_latency_r2: assert property (@(posedge clk) disable iff (rst)
    dout_valid == (en_cnt == LAT));

  // R4: a low enable freezes the result and its flag
  p_freeze_r4: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(dout) && $stable(dout_valid)));

  // R5: once raised, valid stays high until reset
  p_valid_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    dout_valid |=> dout_valid);

  // R6: the cycle after a reset edge shows a cleared output
  p_reset_clear_r6: assert property (@(posedge clk)
    $past(rst) |-> (dout == '0 && !dout_valid));

endmodule

// File: tb/fir_tree_filter_tb.sv
module fir_tree_filter_tb;

  localparam int CLK_P = 10;
  localparam int DW    = 8;
  localparam int CW    = 8;
  localparam int NT    = 5;
  localparam int OW    = DW + CW + 3;
  localparam logic [NT*CW-1:0] COEFS = {8'hF9, 8'h01, 8'h05, 8'hFE, 8'h03};
  localparam int LAT_A = 5;
  localparam int LAT_B = 6;

  // coefficient values of the bench model, tap 0 first
  int coef [NT] = '{3, -2, 5, 1, -7};

  localparam int NV = 34;
  // each entry: {ce, din}
  localparam logic [8:0] VEC [NV] = '{
    {1'b1, 8'h01}, {1'b1, 8'h00}, {1'b1, 8'h00}, {1'b1, 8'h00},
    {1'b1, 8'h00}, {1'b1, 8'h00}, {1'b1, 8'h00}, {1'b1, 8'h00},
    {1'b1, 8'h0A}, {1'b1, 8'hFD}, {1'b0, 8'h63}, {1'b0, 8'hCE},
    {1'b1, 8'h07}, {1'b1, 8'hEC}, {1'b1, 8'h7F}, {1'b1, 8'h7F},
    {1'b1, 8'h7F}, {1'b1, 8'h7F}, {1'b1, 8'h7F}, {1'b1, 8'h7F},
    {1'b1, 8'h80}, {1'b1, 8'h80}, {1'b1, 8'h80}, {1'b1, 8'h80},
    {1'b1, 8'h80}, {1'b1, 8'h80}, {1'b0, 8'h05}, {1'b1, 8'h00},
    {1'b1, 8'h00}, {1'b1, 8'h00}, {1'b1, 8'h00}, {1'b1, 8'h00},
    {1'b1, 8'h00}, {1'b1, 8'h00}
  };

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 ce  = 1'b0;
  logic signed [DW-1:0] din = '0;
  logic signed [OW-1:0] dout_a;
  logic signed [OW-1:0] dout_b;
  logic                 vld_a;
  logic                 vld_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int xs [256];
  int k_acc = 0;

  always #(CLK_P / 2) clk = ~clk;

  fir_tree_filter #(
    .DW(DW), .CW(CW), .NT(NT), .COEFS(COEFS),
    .IN_REG(1), .OUT_REG(1), .MUL_IN_STG(0), .MUL_OUT_STG(0)
  ) u_dut (
    .clk(clk), .rst(rst), .ce(ce), .din(din),
    .dout(dout_a), .dout_valid(vld_a)
  );

  fir_tree_filter #(
    .DW(DW), .CW(CW), .NT(NT), .COEFS(COEFS),
    .IN_REG(0), .OUT_REG(0), .MUL_IN_STG(1), .MUL_OUT_STG(2)
  ) u_dut_b (
    .clk(clk), .rst(rst), .ce(ce), .din(din),
    .dout(dout_b), .dout_valid(vld_b)
  );

  function automatic longint model_y(input int lat);
    int n;
    longint acc;
    n   = k_acc - lat;
    acc = 0;
    if (n < 0) return 0;
    for (int j = 0; j < NT; j++)
      if (n - j >= 0) acc += longint'(coef[j]) * longint'(xs[n-j]);
    return acc;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, longint'(dout_a), model_y(LAT_A));
    chk("R7", longint'(dout_b), model_y(LAT_B));
    chk("R5", longint'(vld_a), longint'(k_acc >= LAT_A));
    chk("R5", longint'(vld_b), longint'(k_acc >= LAT_B));
  endtask

  task automatic step(input bit ce_v, input int d_v);
    @(negedge clk);
    ce  = ce_v;
    din = d_v[DW-1:0];
    @(posedge clk);
    #1;
    if (ce_v) begin
      xs[k_acc] = d_v;
      k_acc++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    ce  = 1'b1;
    din = 8'sd55;
    @(posedge clk);
    #1;
    k_acc = 0;
    @(negedge clk);
    rst = 1'b0;
    ce  = 1'b0;
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int first_a;
    int first_b;
    string tag;
    repeat (3) @(posedge clk);
    #1;
    // R6: state held in reset
    chk("R6", longint'(dout_a), 0);
    chk("R6", longint'(vld_a), 0);
    chk("R6", longint'(dout_b), 0);
    chk("R6", longint'(vld_b), 0);
    @(negedge clk);
    rst = 1'b0;

    // table walk: impulse, mixed signs, enable gaps, full-scale runs
    for (int v = 0; v < NV; v++) begin
      int dv;
      dv = int'(signed'(VEC[v][7:0]));
      step(VEC[v][8], dv);
      if (!VEC[v][8])                 tag = "R4";
      else if (dv >= 127 || dv <= -128) tag = "R3";
      else                            tag = "R1";
      check_all(tag);
    end

    // R4: garbage on din during a long enable gap leaves outputs untouched
    begin
      longint hold_a;
      longint hold_b;
      hold_a = longint'(dout_a);
      hold_b = longint'(dout_b);
      for (int i = 0; i < 4; i++) step(1'b0, 100 - 60 * i);
      chk("R4", longint'(dout_a), hold_a);
      chk("R4", longint'(dout_b), hold_b);
    end

    // R6: reset in the middle of a stream, with enable and data active
    step(1'b1, 90);
    step(1'b1, -90);
    do_reset();
    #1;
    chk("R6", longint'(dout_a), 0);
    chk("R6", longint'(vld_a), 0);
    chk("R6", longint'(dout_b), 0);
    chk("R6", longint'(vld_b), 0);

    // R2 / R7: edge count at which an impulse of 50 first shows up
    first_a = -1;
    first_b = -1;
    for (int i = 0; i < 10; i++) begin
      step(1'b1, (i == 0) ? 50 : 0);
      check_all("R1");
      if (first_a < 0 && dout_a != 0) first_a = k_acc;
      if (first_b < 0 && dout_b != 0) first_b = k_acc;
    end
    chk("R2", longint'(first_a), LAT_A);
    chk("R7", longint'(first_b), LAT_B);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule